// File: doc/BRIEF.md
# Phase-Accumulator Step Pulse Generator

This block turns a signed velocity word into step and direction pulses for one motor axis by direct digital synthesis. A host rewrites the velocity word about once a millisecond. On every update tick, which comes at 1 MHz or faster, the word is added to a phase accumulator. A carry out of the accumulator's top bit means one step forward. With a negative word, a borrow out of the top bit means one step in reverse. The accumulator is never cleared when the command changes. Its value is the fractional part of the axis position, so the stream of pulses follows the integral of the commanded velocity exactly and the axis can run open loop.

The step rate for a command `v` is `v * f_tick / 2^ACC_W`. The rates are exact and evenly spaced. An optional fixed post-scaler keeps a net count of accumulator events and emits one step per `POST_DIV` events. A pulse shaper places the direction level at least one clock before each step edge and stretches each step to a fixed width. The accumulator is visible on an output port so the host can read the fine position.

Top module: `dds_step_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first tick, the accumulator reads zero, the post-scaler count is zero, and both `step` and `dir` are low.
- R2: On a clock with `tick` high, `acc_pos` becomes `(acc_pos + vel_cmd) mod 2^ACC_W`. On a clock with `tick` low, it keeps its value.
- R3: For a non-negative `vel_cmd` (bit ACC_W-1 clear), a tick whose sum carries out of bit ACC_W-1 counts one forward event.
- R4: For a negative `vel_cmd` (two's complement, bit ACC_W-1 set), a tick whose sum makes no carry out of bit ACC_W-1 (a borrow) counts one reverse event. The reverse direction is signalled with `dir` high and the forward direction with `dir` low.
- R5: A change of `vel_cmd` never alters `acc_pos`. The step count over any sequence of commands equals the integer part of the summed command values divided by 2^ACC_W.
- R6: A zero command produces no step pulses and leaves `acc_pos` unchanged.
- R7: The post-scaler holds a count in 0..POST_DIV-1. A forward event at count POST_DIV-1 wraps the count to 0 and emits a forward step; otherwise it increments the count. A reverse event at count 0 wraps the count to POST_DIV-1 and emits a reverse step; otherwise it decrements the count. With POST_DIV = 1, every event is a step.
- R8: `dir` takes its value for a step at least one clock before `step` rises, and holds that value for the whole time `step` is high.
- R9: Each step pulse is high for exactly PULSE_W clocks and rises three clocks after the tick that caused it. This holds provided ticks are at least PULSE_W+2 clocks apart.
- R10: At the command extremes (0x7FFF and 0x8000 for ACC_W = 16), no tick ever produces more than one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Accumulator update enable, one clock wide |
| vel_cmd | input | ACC_W | Signed two's-complement velocity per tick |
| step | output | 1 | Step pulse, PULSE_W clocks high |
| dir | output | 1 | Direction, high for reverse |
| acc_pos | output | ACC_W | Current accumulator (fine position) |

## Verification
The bench runs a reference accumulator and a reference post-scaler with POST_DIV = 3. It compares `acc_pos` after every tick and the forward and reverse step totals before the next tick. A design that tested the sign of the sum rather than the carry would step at the wrong phase, or twice. A design that cleared the accumulator on a command change would lose fractional position when a slow command alternates with its negation.

Directed cases cover the command extremes, plus and minus one, zero, and a reset in the middle of a run. A design that confused carry with borrow for negative commands would drift by one step on each crossing. Pulse width and the direction setup and hold are measured at every step edge, so a shaper that changed `dir` together with `step` is caught.

// File: rtl/dds_step_pkg.sv
package dds_step_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SETUP = 2'd1,
    SH_HIGH  = 2'd2
  } shaper_st_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ACC_W-1:0] vel,
  output logic [ACC_W-1:0] acc,
  output logic             fwd_evt,
  output logic             rev_evt
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic             vel_neg;

  assign vel_neg = vel[ACC_W-1];
  assign sum     = {1'b0, acc_q} + {1'b0, vel};

  always_comb begin
    acc_d   = acc_q;
    fwd_evt = 1'b0;
    rev_evt = 1'b0;
    if (tick) begin
      acc_d   = sum[ACC_W-1:0];
      fwd_evt = !vel_neg &&  sum[ACC_W];
      rev_evt =  vel_neg && !sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R2: accumulator moves only on a tick
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));

  // R6: zero command leaves the accumulator in place
  a_r6_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && vel == '0) |=> $stable(acc_q));
endmodule

// File: rtl/dds_post_scaler.sv
module dds_post_scaler #(
  parameter int POST_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_in,
  input  logic rev_in,
  output logic fwd_out,
  output logic rev_out
);
  localparam int CNT_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(POST_DIV - 1);

  logic fwd_q, rev_q, fwd_d, rev_d;

  generate
    if (POST_DIV == 1) begin : g_bypass
      always_comb begin
        fwd_d = fwd_in;
        rev_d = rev_in;
      end
    end else begin : g_divide
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        fwd_d = 1'b0;
        rev_d = 1'b0;
        if (fwd_in) begin
          if (cnt_q == CNT_TOP) begin
            cnt_d = '0;
            fwd_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (rev_in) begin
          if (cnt_q == '0) begin
            cnt_d = CNT_TOP;
            rev_d = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R7: count stays inside 0..POST_DIV-1
      a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
      // R7: a forward step only leaves a wrapped count of zero
      a_r7_fwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q |-> cnt_q == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
      rev_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
      rev_q <= rev_d;
    end
  end

  assign fwd_out = fwd_q;
  assign rev_out = rev_q;

  // R10: never a forward and a reverse step together
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_q, rev_q}));
endmodule

// File: rtl/dds_pulse_shaper.sv
module dds_pulse_shaper
  import dds_step_pkg::*;
#(
  parameter int PULSE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_evt,
  input  logic rev_evt,
  output logic step,
  output logic dir
);
  localparam int WC_W = $clog2(PULSE_W + 1);
  localparam logic [WC_W-1:0] WC_END = WC_W'(PULSE_W);

  shaper_st_e      st_q, st_d;
  logic [WC_W-1:0] wc_q, wc_d;
  logic            step_q, step_d, dir_q, dir_d;

  always_comb begin
    st_d   = st_q;
    wc_d   = wc_q;
    step_d = step_q;
    dir_d  = dir_q;
    unique case (st_q)
      SH_IDLE: begin
        if (fwd_evt || rev_evt) begin
          dir_d = rev_evt;
          st_d  = SH_SETUP;
        end
      end
      SH_SETUP: begin
        step_d = 1'b1;
        wc_d   = WC_W'(1);
        st_d   = SH_HIGH;
      end
      SH_HIGH: begin
        if (wc_q == WC_END) begin
          step_d = 1'b0;
          wc_d   = '0;
          st_d   = SH_IDLE;
        end else begin
          wc_d = wc_q + 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      wc_q   <= '0;
      step_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wc_q   <= wc_d;
      step_q <= step_d;
      dir_q  <= dir_d;
    end
  end

  assign step = step_q;
  assign dir  = dir_q;

  // independent high-time counter for the width check
  logic [WC_W:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len_q <= '0;
    else if (step_q) hi_len_q <= hi_len_q + 1'b1;
    else             hi_len_q <= '0;
  end

  // R8: direction settled one clock ahead of the rising edge
  a_r8_dir_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_q) |-> $stable(dir_q));
  // R8: direction held while step is high
  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && $past(step_q)) |-> $stable(dir_q));
  // R9: pulse width
  a_r9_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_q) |-> hi_len_q == (WC_W + 1)'(PULSE_W));
endmodule

// File: rtl/dds_step_gen.sv
module dds_step_gen #(
  parameter int ACC_W    = 16,
  parameter int POST_DIV = 1,
  parameter int PULSE_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ACC_W-1:0] vel_cmd,
  output logic             step,
  output logic             dir,
  output logic [ACC_W-1:0] acc_pos
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       acc_fwd, acc_rev, ps_fwd, ps_rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .vel     (vel_cmd),
    .acc     (acc_pos),
    .fwd_evt (acc_fwd),
    .rev_evt (acc_rev)
  );

  dds_post_scaler #(.POST_DIV(POST_DIV)) u_post (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fwd_in  (acc_fwd),
    .rev_in  (acc_rev),
    .fwd_out (ps_fwd),
    .rev_out (ps_rev)
  );

  dds_pulse_shaper #(.PULSE_W(PULSE_W)) u_shape (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fwd_evt (ps_fwd),
    .rev_evt (ps_rev),
    .step    (step),
    .dir     (dir)
  );

  // R1: outputs quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!step && !dir && acc_pos == '0));
endmodule

// File: tb/tb_dds_step_gen.sv
module tb_dds_step_gen;
  localparam int ACC_W = 16;
  localparam int M     = 3;
  localparam int PW    = 3;
  localparam int TICKP = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tick;
  logic [ACC_W-1:0] vel_cmd;
  logic             step, dir;
  logic [ACC_W-1:0] acc_pos;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int unsigned m_acc;
  int          m_cnt;
  int          exp_fwd, exp_rev, got_fwd, got_rev;
  int          hi_len;
  logic        prev_step, prev_dir;

  always #4 clk = ~clk;

  dds_step_gen #(.ACC_W(ACC_W), .POST_DIV(M), .PULSE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vel_cmd(vel_cmd),
    .step(step), .dir(dir), .acc_pos(acc_pos)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // step monitor: counts edges, measures width and direction setup/hold
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_len = 0;
    end else begin
      if (step && !prev_step) begin
        check("R8 dir setup", dir, prev_dir);
        if (dir) got_rev++; else got_fwd++;
        hi_len = 1;
      end else if (step) begin
        check("R8 dir hold", dir, prev_dir);
        hi_len++;
      end else if (prev_step) begin
        check("R9 pulse width", hi_len, PW);
      end
    end
    prev_step = step;
    prev_dir  = dir;
  end

  // reference model for one tick
  task automatic model_tick(input logic [ACC_W-1:0] v);
    int unsigned s;
    bit ev_f, ev_r;
    s    = m_acc + v;
    ev_f = !v[ACC_W-1] &&  s[ACC_W];
    ev_r =  v[ACC_W-1] && !s[ACC_W];
    m_acc = s & ((1 << ACC_W) - 1);
    if (ev_f) begin
      if (m_cnt == M-1) begin m_cnt = 0; exp_fwd++; end else m_cnt++;
    end else if (ev_r) begin
      if (m_cnt == 0) begin m_cnt = M-1; exp_rev++; end else m_cnt--;
    end
  endtask

  task automatic do_tick(input logic [ACC_W-1:0] v, input string req);
    int pf, pr;
    pf = got_fwd; pr = got_rev;
    @(negedge clk);
    vel_cmd = v;
    tick    = 1'b1;
    model_tick(v);
    @(negedge clk);
    tick = 1'b0;
    check({"R2 acc ", req}, acc_pos, m_acc);
    repeat (TICKP - 2) @(negedge clk);
    check({"R3 R4 R7 fwd ", req}, got_fwd, exp_fwd);
    check({"R3 R4 R7 rev ", req}, got_rev, exp_rev);
    check("R10 single step", (got_fwd - pf) + (got_rev - pr) <= 1, 1);
  endtask

  task automatic do_reset();
    tick = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 step", step, 0);
    check("R1 dir", dir, 0);
    check("R1 acc", acc_pos, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 acc after release", acc_pos, 0);
    m_acc = 0; m_cnt = 0;
    exp_fwd = got_fwd; exp_rev = got_rev;
  endtask

  initial begin
    int sf, sr;
    logic [ACC_W-1:0] a0;
    vel_cmd = '0; tick = 1'b0; rst_n = 1'b0;
    got_fwd = 0; got_rev = 0; prev_step = 0; prev_dir = 0;
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R6: zero command
    for (int i = 0; i < 20; i++) do_tick('0, "zero");
    check("R6 no steps", got_fwd + got_rev, 0);

    // R2: no tick means no change
    a0 = acc_pos;
    vel_cmd = 16'h1234;
    repeat (10) @(negedge clk);
    check("R2 hold without tick", acc_pos, a0);

    // R3 boundary: smallest and largest forward
    for (int i = 0; i < 40; i++) do_tick(16'h0001, "plus one");
    for (int i = 0; i < 60; i++) do_tick(16'h7FFF, "max fwd");
    // R4 boundary: minus one and most negative
    for (int i = 0; i < 40; i++) do_tick(16'hFFFF, "minus one");
    for (int i = 0; i < 60; i++) do_tick(16'h8000, "max rev");

    // R5: alternating commands keep position as integral
    sf = got_fwd; sr = got_rev;
    for (int i = 0; i < 200; i++) begin
      do_tick(16'h5000, "R5 alt a");
      do_tick(16'hB000, "R5 alt b");
    end
    check("R5 net zero", (got_fwd - sf) - (got_rev - sr), 0);

    // random segments with command changes
    for (int seg = 0; seg < 40; seg++) begin
      logic [ACC_W-1:0] v;
      int len;
      v   = ACC_W'($urandom);
      len = 20 + int'($urandom % 40);
      for (int k = 0; k < len; k++) do_tick(v, "random");
    end

    // R1: reset mid run
    do_tick(16'h4321, "pre reset");
    do_reset();
    for (int i = 0; i < 30; i++) do_tick(16'hC001, "after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule